// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from a storage-card host controller (command engine, data path, DMA) into two 16-bit latched status registers: a normal group and an error group. A per-group latch mask decides which pulses are allowed to set a status bit. A separate per-group enable decides which latched bits may drive the single interrupt line. Software clears a latched bit by writing a 1 to it.

The normal group's top bit is a summary bit. It is not stored. It reads as 1 whenever any error status bit is latched with its latch mask set, so clearing the error bits also clears the summary. A control register carries a soft-reset bit. Setting it empties every register and holds the block idle for a fixed number of cycles.

All register access goes through one plain synchronous write port and one combinational read port that share an address. The block has no streaming data interface, so no valid/ready handshake applies and no back-pressure exists. The register address map is: 0 normal status, 1 error status, 2 normal latch mask, 3 error latch mask, 4 normal interrupt enable, 5 error interrupt enable, 6 control, 7 reserved.

Top module: `irq_status_unit`

## Requirements
- R1: After reset every register reads 0 and `irq_out` is 0.
- R2: A pulse on `norm_evt[b]` whose normal latch mask bit is 1 sets normal status bit b at the next clock edge. The implemented normal bits are 0 (command done), 1 (data done), 2 (block gap), 3 (DMA done), 4 (write ready), 5 (read ready), 8 (card interrupt) and 10 (read burst ready). A pulse whose mask bit is 0 sets nothing.
- R3: A pulse on `err_evt[b]` latches the same way into error status. The implemented error bits are 4 (data timeout), 5 (data CRC), 6 (data end bit), 8 (auto stop-command error), 10 (transfer size), 11 (response T-bit), 12 (CRC end bit), 13 (CRC start bit) and 14 (CRC status). Any bit that is not implemented, in either group, never sets and always reads 0.
- R4: Writing a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: If an event and a write-1-clear of the same bit occur in the same cycle, the bit stays set.
- R6: Normal status bit 15 reads as the OR of (error status AND error latch mask). Writes to it have no effect, and it falls as soon as the contributing error bits are cleared or their mask bits are cleared.
- R7: `irq_out` equals, one cycle later, the OR over both groups of the status as read ANDed with the enable. The normal enable bit 15 gates the summary bit. With both enables at 0, `irq_out` stays 0.
- R8: Writing the control register with bit 8 set clears all status, mask and enable registers. Control bit 8 then reads 1 for `RST_CYCLES` cycles. During that time events and register writes are ignored.
- R9: The mask and enable registers read back only their implemented bits. Normal enable additionally keeps bit 15. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| norm_evt | input | 16 | Normal event pulses, one bit per status position |
| err_evt | input | 16 | Error event pulses, one bit per status position |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data of the register at `reg_addr` |
| irq_out | output | 1 | Registered interrupt line |

## Verification
The bench sweeps all 16 event positions of each group with the latch masks fully open and then fully closed. This separates implemented bits from unimplemented ones and shows that gating happens at latch time. Partial clear patterns and a same-cycle event-plus-clear show the difference between plain write-1-clear and the priority given to events. The interrupt line is tried with all enables off, with one enable on a single normal bit, and through the summary bit alone, which shows the one-cycle lag and the two-level gating. A soft reset issued with registers loaded, then pelted with events and writes during its busy window, shows that clearing is complete and that input is ignored while busy.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 3;
  localparam int SRST_BIT = 8;
  localparam int SUMMARY_BIT = 15;

  localparam logic [REG_W-1:0] NORM_IMPL_DEF = 16'h053F;
  localparam logic [REG_W-1:0] ERR_IMPL_DEF  = 16'h7D70;

  typedef enum logic [ADDR_W-1:0] {
    RA_NSTAT = 3'd0,
    RA_ESTAT = 3'd1,
    RA_NMASK = 3'd2,
    RA_EMASK = 3'd3,
    RA_NEN   = 3'd4,
    RA_EEN   = 3'd5,
    RA_CTRL  = 3'd6,
    RA_RSVD  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_event_bank.sv
module irq_event_bank #(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL = '1,
  parameter logic [W-1:0] EN_IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_all,
  input  logic [W-1:0] evt,
  input  logic         wr_stat,
  input  logic         wr_mask,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat,
  output logic [W-1:0] mask,
  output logic [W-1:0] en
);
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;
  logic [W-1:0] stat_nx;

  // events that pass the latch mask; mask holds implemented bits only
  assign set_v   = evt & mask;
  assign clr_v   = wr_stat ? wdata : '0;
  // set term applied after clear: a same-cycle event wins
  assign stat_nx = (stat & ~clr_v) | set_v;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_all) begin
      stat <= '0;
      mask <= '0;
      en   <= '0;
    end else begin
      stat <= stat_nx & IMPL;
      if (wr_mask) mask <= wdata & IMPL;
      if (wr_en)   en   <= wdata & EN_IMPL;
    end
  end
endmodule

// File: rtl/irq_srst_seq.sv
module irq_srst_seq #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (req && cnt == '0) begin
      cnt <= LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_low,
  input  logic [W-1:0] n_view,
  input  logic [W-1:0] n_en,
  input  logic [W-1:0] e_stat,
  input  logic [W-1:0] e_en,
  output logic         irq
);
  logic any_n;
  logic any_e;

  assign any_n = |(n_view & n_en);
  assign any_e = |(e_stat & e_en);

  always_ff @(posedge clk) begin
    if (!rst_n || hold_low) irq <= 1'b0;
    else                    irq <= any_n | any_e;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  parameter logic [REG_W-1:0] NORM_IMPL = NORM_IMPL_DEF,
  parameter logic [REG_W-1:0] ERR_IMPL  = ERR_IMPL_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  norm_evt,
  input  logic [REG_W-1:0]  err_evt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_out
);
  localparam logic [REG_W-1:0] SUM_MASK   = REG_W'(1) << SUMMARY_BIT;
  localparam logic [REG_W-1:0] N_STORE    = NORM_IMPL & ~SUM_MASK;
  localparam logic [REG_W-1:0] N_EN_IMPL  = N_STORE | SUM_MASK;

  reg_sel_e         sel;
  logic             srst_busy;
  logic             srst_req;
  logic             clear_all;
  logic             wr_ok;
  logic [REG_W-1:0] n_stat, n_mask, n_en;
  logic [REG_W-1:0] e_stat, e_mask, e_en;
  logic [REG_W-1:0] n_view;
  logic             summary;

  assign sel       = reg_sel_e'(reg_addr);
  assign wr_ok     = reg_wr && !srst_busy;
  assign srst_req  = wr_ok && sel == RA_CTRL && reg_wdata[SRST_BIT];
  assign clear_all = srst_req || srst_busy;

  irq_srst_seq #(.CYCLES(RST_CYCLES)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (srst_req),
    .busy  (srst_busy)
  );

  irq_event_bank #(.W(REG_W), .IMPL(N_STORE), .EN_IMPL(N_EN_IMPL)) u_norm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (clear_all),
    .evt       (norm_evt),
    .wr_stat   (wr_ok && sel == RA_NSTAT),
    .wr_mask   (wr_ok && sel == RA_NMASK),
    .wr_en     (wr_ok && sel == RA_NEN),
    .wdata     (reg_wdata),
    .stat      (n_stat),
    .mask      (n_mask),
    .en        (n_en)
  );

  irq_event_bank #(.W(REG_W), .IMPL(ERR_IMPL), .EN_IMPL(ERR_IMPL)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (clear_all),
    .evt       (err_evt),
    .wr_stat   (wr_ok && sel == RA_ESTAT),
    .wr_mask   (wr_ok && sel == RA_EMASK),
    .wr_en     (wr_ok && sel == RA_EEN),
    .wdata     (reg_wdata),
    .stat      (e_stat),
    .mask      (e_mask),
    .en        (e_en)
  );

  // summary of latched errors whose latch mask is still open
  assign summary = |(e_stat & e_mask);
  assign n_view  = n_stat | (summary ? SUM_MASK : '0);

  irq_line_drv #(.W(REG_W)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_low (clear_all),
    .n_view   (n_view),
    .n_en     (n_en),
    .e_stat   (e_stat),
    .e_en     (e_en),
    .irq      (irq_out)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      RA_NSTAT: reg_rdata = n_view;
      RA_ESTAT: reg_rdata = e_stat;
      RA_NMASK: reg_rdata = n_mask;
      RA_EMASK: reg_rdata = e_mask;
      RA_NEN:   reg_rdata = n_en;
      RA_EEN:   reg_rdata = e_en;
      RA_CTRL:  reg_rdata[SRST_BIT] = srst_busy;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_pkg::*;
#(
  parameter logic [REG_W-1:0] NORM_IMPL = NORM_IMPL_DEF,
  parameter logic [REG_W-1:0] ERR_IMPL  = ERR_IMPL_DEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_W-1:0]  norm_evt,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              irq_out,
  input logic [REG_W-1:0]  n_stat,
  input logic [REG_W-1:0]  e_stat,
  input logic [REG_W-1:0]  n_mask,
  input logic [REG_W-1:0]  e_mask,
  input logic [REG_W-1:0]  n_en,
  input logic [REG_W-1:0]  e_en,
  input logic              srst_busy
);
  logic ctrl_hit;
  logic [REG_W-1:0] pass_n;
  assign ctrl_hit = reg_wr && reg_addr == 3'd6 && reg_wdata[SRST_BIT];
  assign pass_n   = norm_evt & n_mask;

  // R2: a mask-passed normal event is latched at the next edge
  a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_busy && !ctrl_hit && pass_n != '0)
      |=> ((n_stat & $past(pass_n)) == $past(pass_n)));

  // R3: bits outside the implemented sets never become set
  a_r3_impl_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((n_stat & ~NORM_IMPL) == '0) && ((e_stat & ~ERR_IMPL) == '0));

  // R4: a write-1-clear with no competing event empties those bits
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_busy && reg_wr && reg_addr == 3'd0 && (reg_wdata & pass_n) == '0)
      |=> ((n_stat & $past(reg_wdata)) == '0));

  // R7: with both enables zero the line is low next cycle
  a_r7_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    (n_en == '0 && e_en == '0) |=> !irq_out);

  // R8: while soft reset is busy every register stays empty
  a_r8_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (n_stat == '0 && e_stat == '0 && n_mask == '0 &&
                   e_mask == '0 && n_en == '0 && e_en == '0));
endmodule

bind irq_status_unit irq_status_chk #(.NORM_IMPL(NORM_IMPL), .ERR_IMPL(ERR_IMPL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .norm_evt  (norm_evt),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_out   (irq_out),
  .n_stat    (n_stat),
  .e_stat    (e_stat),
  .n_mask    (n_mask),
  .e_mask    (e_mask),
  .n_en      (n_en),
  .e_en      (e_en),
  .srst_busy (srst_busy)
);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
  localparam int RSTC = 4;
  localparam logic [15:0] NIMP = 16'h053F;
  localparam logic [15:0] EIMP = 16'h7D70;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] norm_evt = '0;
  logic [15:0] err_evt = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_status_unit #(.RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .rst_n(rst_n), .norm_evt(norm_evt), .err_evt(err_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [15:0] n, input logic [15:0] e);
    @(negedge clk);
    norm_evt = n; err_evt = e;
    @(negedge clk);
    norm_evt = '0; err_evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 reg %0d", a), d, 16'h0);
    end
    check("R1 irq", {15'd0, irq_out}, 16'h0);

    // R9 readback of masks and enables
    wr(3'd2, 16'hFFFF); rd(3'd2, d); check("R9 nmask", d, NIMP);
    wr(3'd3, 16'hFFFF); rd(3'd3, d); check("R9 emask", d, EIMP);
    wr(3'd4, 16'hFFFF); rd(3'd4, d); check("R9 nen", d, NIMP | 16'h8000);
    wr(3'd4, 16'h0000);
    rd(3'd7, d); check("R9 reserved", d, 16'h0);

    // R2 / R3 / R6 sweep with masks open
    for (int b = 0; b < 16; b++) begin
      logic [15:0] bit_v;
      bit_v = 16'h1 << b;
      pulse(bit_v, 16'h0);
      rd(3'd0, d);
      check($sformatf("R2 norm bit %0d", b), d, bit_v & NIMP & 16'h7FFF);
      wr(3'd0, 16'hFFFF);
      rd(3'd0, d);
      check($sformatf("R4 norm clr %0d", b), d, 16'h0);
      pulse(16'h0, bit_v);
      rd(3'd1, d);
      check($sformatf("R3 err bit %0d", b), d, bit_v & EIMP);
      rd(3'd0, d);
      check($sformatf("R6 summary %0d", b), d, ((bit_v & EIMP) != 0) ? 16'h8000 : 16'h0);
      wr(3'd1, 16'hFFFF);
      rd(3'd0, d);
      check($sformatf("R6 summary clr %0d", b), d, 16'h0);
    end

    // R2 / R3 masks closed: nothing latches
    wr(3'd2, 16'h0); wr(3'd3, 16'h0);
    pulse(16'hFFFF, 16'hFFFF);
    rd(3'd0, d); check("R2 masked norm", d, 16'h0);
    rd(3'd1, d); check("R3 masked err", d, 16'h0);

    // R4 partial clear
    wr(3'd2, 16'hFFFF);
    pulse(16'hFFFF, 16'h0);
    wr(3'd0, 16'h0005);
    rd(3'd0, d); check("R4 partial clr", d, 16'h053A);

    // R5 event and clear in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0003; norm_evt = 16'h0001;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; norm_evt = '0;
    rd(3'd0, d); check("R5 event wins", d, 16'h0539);
    wr(3'd0, 16'hFFFF);

    // R6 summary ignores writes, follows error mask
    wr(3'd3, 16'hFFFF);
    pulse(16'h0, 16'h0010);
    wr(3'd0, 16'h8000);
    rd(3'd0, d); check("R6 write ignored", d, 16'h8000);
    wr(3'd3, 16'h0000);
    rd(3'd0, d); check("R6 mask drops summary", d, 16'h0);
    rd(3'd1, d); check("R6 err kept", d, 16'h0010);
    wr(3'd1, 16'hFFFF);

    // R7 interrupt line
    pulse(16'h0002, 16'h0);
    @(negedge clk);
    check("R7 enables off", {15'd0, irq_out}, 16'h0);
    wr(3'd4, 16'h0002);
    @(negedge clk);
    check("R7 enabled bit", {15'd0, irq_out}, 16'h1);
    wr(3'd0, 16'h0002);
    check("R7 lag after clear", {15'd0, irq_out}, 16'h1);
    @(negedge clk);
    check("R7 low after clear", {15'd0, irq_out}, 16'h0);
    wr(3'd3, 16'hFFFF);
    wr(3'd4, 16'h8000);
    pulse(16'h0, 16'h4000);
    check("R7 summary lag", {15'd0, irq_out}, 16'h0);
    @(negedge clk);
    check("R7 summary irq", {15'd0, irq_out}, 16'h1);

    // R8 soft reset
    wr(3'd5, 16'hFFFF);
    pulse(16'h0001, 16'h0);
    wr(3'd6, 16'h0100);
    rd(3'd6, d); check("R8 busy set", d, 16'h0100);
    rd(3'd3, d); check("R8 emask cleared", d, 16'h0);
    norm_evt = 16'hFFFF; err_evt = 16'hFFFF;
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 16'hFFFF;
    repeat (RSTC - 1) @(negedge clk);
    reg_wr = 1'b0; norm_evt = '0; err_evt = '0;
    rd(3'd6, d); check("R8 busy still", d, 16'h0100);
    @(negedge clk);
    rd(3'd6, d); check("R8 busy ends", d, 16'h0);
    rd(3'd2, d); check("R8 write ignored", d, 16'h0);
    rd(3'd0, d); check("R8 nstat empty", d, 16'h0);
    rd(3'd1, d); check("R8 estat empty", d, 16'h0);
    rd(3'd4, d); check("R8 nen empty", d, 16'h0);
    check("R8 irq low", {15'd0, irq_out}, 16'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule